// File: doc/BRIEF.md
# Hashed Binary-Tree Walker

This engine moves a batch of walkers through an implicit perfect binary tree held in a flat memory of 32-bit words. The node of index `i` has children `2i+1` and `2i+2`. Every operand is found through a seven-word header at address 0. Software fills the memory, pulses `start`, and waits for `done`.

Each walker slot holds a current value and a node index. For every walker the engine fetches the node value at the walker's index and mixes it into the walker's value with a six-stage 32-bit hash. The parity of the result picks the child, and the index falls back to the root once it leaves the tree. The new value and index are written back to the walker's slots. Walkers are handled one at a time in batch order, and the whole batch is repeated for the given number of rounds.

The memory is single-port and synchronous, with one cycle of read latency. The engine drives every access itself. The header is read once per job, and after that each walker costs five consecutive memory cycles.

Top module: `tree_walk_engine`

## Requirements
- R1: When `start` is sampled high while idle, the engine reads addresses 0 to 6 in order on seven consecutive cycles, starting in the cycle after that edge. It then makes no access for one cycle. A read's data is taken from `mem_rdata` in the cycle after the read is issued. Word 0 is the round count, word 1 the node count, word 2 the batch size, word 3 the height (unused), word 4 the node-value base, word 5 the index base and word 6 the value base.
- R2: For walker `w`, the engine runs five consecutive cycles: read index base+w, read value base+w, read node base+index, write value base+w, write index base+w. All address sums are truncated to ADDR_W bits.
- R3: The written value is H(value XOR node value). H is applied in six stages, each `a = f2(f1(a,K), g(a,S))` with all arithmetic modulo 2^32. The stages, in order, are: (+,0x7ED55D16,+,<<,12), (^,0xC761C23C,^,>>,19), (+,0x165667B1,+,<<,5), (+,0xD3A2646C,^,<<,9), (+,0xFD7046C5,+,<<,3), (^,0xB55A4F09,^,>>,16).
- R4: The candidate next index is 2*index+1 when the new value is even and 2*index+2 when it is odd.
- R5: When the candidate, taken without 32-bit overflow, is greater than or equal to the node count, the written index is 0.
- R6: Walkers are processed in ascending batch order within a round, and each round runs the full batch. The walker of the next round follows the last walker of the previous round with no gap cycle.
- R7: A round count of 0 or a batch size of 0 gives no write. In that case `done` is raised in the cycle right after the idle cycle that follows the header reads.
- R8: `done` is a one-cycle pulse in the cycle right after the final index write, and no memory access happens in that cycle.
- R9: `start` has no effect from the first header read up to and including the `done` cycle.
- R10: After reset, and whenever idle, `done` and `mem_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launches a job when idle |
| done | output | 1 | One-cycle end-of-job pulse |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after the read |

## Verification
The hardest cases to reach are a `start` pulse that arrives in the middle of a walker sequence or in the `done` cycle itself, and a candidate index that overflows 32 bits. The bench drives a second `start` at a chosen point in the schedule and on the `done` cycle. It then shows that the per-cycle access stream still matches the model and stays quiet afterwards. For the overflow case, one job sets the node count to 0xFFFFFFFF with a walker at index 0x80000000, so that only a 33-bit compare wraps the index to 0. Tree shapes are chosen so that every walker reaches a leaf within the run and is wrapped.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int WORD_W   = 32;
  localparam int N_STAGES = 6;
  localparam int HDR_WORDS = 7;

  typedef enum logic [2:0] {
    S_IDLE, S_HDR, S_RIDX, S_RVAL, S_RNODE, S_WVAL, S_WIDX, S_DONE
  } tw_state_e;

  // One mixing stage: a = f2(f1(a,K), g(a,S)); add_first/add_second pick + over ^.
  function automatic logic [WORD_W-1:0] mix_step(input logic [WORD_W-1:0] a, input int k);
    logic [WORD_W-1:0] kc, lhs, rhs;
    logic add_first, add_second, shl;
    int sh;
    case (k)
      0: begin kc = 32'h7ED55D16; add_first = 1'b1; add_second = 1'b1; shl = 1'b1; sh = 12; end
      1: begin kc = 32'hC761C23C; add_first = 1'b0; add_second = 1'b0; shl = 1'b0; sh = 19; end
      2: begin kc = 32'h165667B1; add_first = 1'b1; add_second = 1'b1; shl = 1'b1; sh = 5;  end
      3: begin kc = 32'hD3A2646C; add_first = 1'b1; add_second = 1'b0; shl = 1'b1; sh = 9;  end
      4: begin kc = 32'hFD7046C5; add_first = 1'b1; add_second = 1'b1; shl = 1'b1; sh = 3;  end
      default: begin kc = 32'hB55A4F09; add_first = 1'b0; add_second = 1'b0; shl = 1'b0; sh = 16; end
    endcase
    lhs = add_first ? (a + kc) : (a ^ kc);
    rhs = shl ? (a << sh) : (a >> sh);
    return add_second ? (lhs + rhs) : (lhs ^ rhs);
  endfunction

  // Child selection with root wrap; the candidate is held in 33 bits.
  function automatic logic [WORD_W-1:0] child_of(input logic [WORD_W-1:0] idx,
                                                 input logic [WORD_W-1:0] hv,
                                                 input logic [WORD_W-1:0] nodes);
    logic [WORD_W:0] cand;
    cand = {idx, 1'b0} + (hv[0] ? 33'd2 : 33'd1);
    return (cand >= {1'b0, nodes}) ? '0 : cand[WORD_W-1:0];
  endfunction
endpackage

// File: rtl/tw_mix_hash.sv
module tw_mix_hash
  import tw_pkg::*;
(
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout
);
  logic [WORD_W-1:0] lane [0:N_STAGES];
  assign lane[0] = din;
  for (genvar k = 0; k < N_STAGES; k++) begin : g_stage
    assign lane[k+1] = mix_step(lane[k], k);
  end
  assign dout = lane[N_STAGES];
endmodule

// File: rtl/tw_child_index.sv
module tw_child_index
  import tw_pkg::*;
(
  input  logic [WORD_W-1:0] cur_idx,
  input  logic [WORD_W-1:0] hashed,
  input  logic [WORD_W-1:0] node_count,
  output logic [WORD_W-1:0] next_idx
);
  assign next_idx = child_of(cur_idx, hashed, node_count);
endmodule

// File: rtl/tree_walk_engine.sv
module tree_walk_engine
  import tw_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              done,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata
);
  localparam int HC_W = $clog2(HDR_WORDS + 1);

  tw_state_e         state;
  logic [HC_W-1:0]   hc;
  logic [WORD_W-1:0] rounds_q, nodes_q, batch_q, nbase_q, ibase_q, vbase_q;
  logic [WORD_W-1:0] round_q, walker_q, idx_q, val_q, hash_q, nidx_q;
  logic [WORD_W-1:0] hash_w, nidx_w;

  // Named events for the checker
  logic busy, wr_val_ev, wr_idx_ev, last_walker, last_round, no_work;
  assign busy        = (state != S_IDLE);
  assign wr_val_ev   = (state == S_WVAL);
  assign wr_idx_ev   = (state == S_WIDX);
  assign last_walker = (walker_q == batch_q - 1);
  assign last_round  = (round_q == rounds_q - 1);
  assign no_work     = (rounds_q == '0) || (batch_q == '0);
  assign done        = (state == S_DONE);

  tw_mix_hash u_hash (
    .din  (val_q ^ mem_rdata),
    .dout (hash_w)
  );

  tw_child_index u_child (
    .cur_idx    (idx_q),
    .hashed     (hash_w),
    .node_count (nodes_q),
    .next_idx   (nidx_w)
  );

  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (state)
      S_HDR: begin
        mem_en   = (hc < HC_W'(HDR_WORDS));
        mem_addr = ADDR_W'(hc);
      end
      S_RIDX:  begin mem_en = 1'b1; mem_addr = ADDR_W'(ibase_q + walker_q); end
      S_RVAL:  begin mem_en = 1'b1; mem_addr = ADDR_W'(vbase_q + walker_q); end
      S_RNODE: begin mem_en = 1'b1; mem_addr = ADDR_W'(nbase_q + idx_q); end
      S_WVAL: begin
        mem_en = 1'b1; mem_we = 1'b1;
        mem_addr = ADDR_W'(vbase_q + walker_q); mem_wdata = hash_w;
      end
      S_WIDX: begin
        mem_en = 1'b1; mem_we = 1'b1;
        mem_addr = ADDR_W'(ibase_q + walker_q); mem_wdata = nidx_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      hc       <= '0;
      rounds_q <= '0; nodes_q <= '0; batch_q <= '0;
      nbase_q  <= '0; ibase_q <= '0; vbase_q <= '0;
      round_q  <= '0; walker_q <= '0;
      idx_q    <= '0; val_q <= '0; hash_q <= '0; nidx_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state <= S_HDR;
          hc    <= '0;
        end
        S_HDR: begin
          case (hc)
            HC_W'(1): rounds_q <= mem_rdata;
            HC_W'(2): nodes_q  <= mem_rdata;
            HC_W'(3): batch_q  <= mem_rdata;
            HC_W'(5): nbase_q  <= mem_rdata;
            HC_W'(6): ibase_q  <= mem_rdata;
            HC_W'(7): vbase_q  <= mem_rdata;
            default: ;
          endcase
          hc <= hc + 1'b1;
          if (hc == HC_W'(HDR_WORDS)) begin
            round_q  <= '0;
            walker_q <= '0;
            state    <= no_work ? S_DONE : S_RIDX;
          end
        end
        S_RIDX:  state <= S_RVAL;
        S_RVAL:  begin idx_q <= mem_rdata; state <= S_RNODE; end
        S_RNODE: begin val_q <= mem_rdata; state <= S_WVAL; end
        S_WVAL: begin
          hash_q <= hash_w;
          nidx_q <= nidx_w;
          state  <= S_WIDX;
        end
        S_WIDX: begin
          if (last_walker) begin
            walker_q <= '0;
            if (last_round) state <= S_DONE;
            else begin
              round_q <= round_q + 1'b1;
              state   <= S_RIDX;
            end
          end else begin
            walker_q <= walker_q + 1'b1;
            state    <= S_RIDX;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tw_engine_chk.sv
module tw_engine_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              mem_en,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic              wr_val_ev,
  input logic              wr_idx_ev,
  input logic [31:0]       nodes_q,
  input logic [31:0]       hash_q
);
  AST_LAUNCH_HEADER: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (mem_en && !mem_we && mem_addr == '0)); // R1
  AST_VALUE_THEN_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    wr_val_ev |=> (wr_idx_ev && mem_we)); // R2
  AST_CHILD_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_idx_ev && mem_wdata != 0) |-> (mem_wdata[0] != hash_q[0])); // R4
  AST_INDEX_IN_TREE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_idx_ev |-> (mem_wdata == 0 || mem_wdata < nodes_q)); // R5
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_en); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_en && !done)); // R10
endmodule

bind tree_walk_engine tw_engine_chk #(.ADDR_W(ADDR_W)) u_tw_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .wr_val_ev(wr_val_ev), .wr_idx_ev(wr_idx_ev), .nodes_q(nodes_q), .hash_q(hash_q)
);

// File: tb/test_tree_walk_engine.sv
module test_tree_walk_engine;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  typedef struct packed {
    logic        en;
    logic        we;
    logic [15:0] addr;
    logic [31:0] wd;
    logic        dn;
    logic [3:0]  tag;
  } cyc_t;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic done, mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;

  logic [31:0] tb_mem  [0:255];
  logic [31:0] ref_mem [0:255];
  cyc_t exp_q[$];
  int checks = 0, failures = 0;
  int unsigned seed = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  tree_walk_engine #(.ADDR_W(AW)) i_tree_walk_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) tb_mem[mem_addr[7:0]] <= mem_wdata;
      else        mem_rdata <= tb_mem[mem_addr[7:0]];
    end
  end

  function automatic string tag_name(input logic [3:0] t);
    case (t)
      1: return "R1";  2: return "R2";  3: return "R3";
      4: return "R4/R5"; 7: return "R7"; 8: return "R8";
      default: return "R9/R10";
    endcase
  endfunction

  // Hash restated as a table walk over integer arrays
  function automatic int unsigned ref_hash(input int unsigned x);
    int unsigned keys [6] = '{32'h7ED55D16, 32'hC761C23C, 32'h165667B1,
                              32'hD3A2646C, 32'hFD7046C5, 32'hB55A4F09};
    int shifts [6] = '{12, -19, 5, 9, 3, -16};   // negative = right shift
    bit plus1 [6] = '{1, 0, 1, 1, 1, 0};
    bit plus2 [6] = '{1, 0, 1, 0, 1, 0};
    int unsigned a = x;
    for (int s = 0; s < 6; s++) begin
      int unsigned p, q;
      p = plus1[s] ? a + keys[s] : a ^ keys[s];
      q = (shifts[s] > 0) ? (a << shifts[s]) : (a >> (-shifts[s]));
      a = plus2[s] ? p + q : p ^ q;
    end
    return a;
  endfunction

  task automatic put(input int a, input int unsigned v);
    tb_mem[a] = v;
    ref_mem[a] = v;
  endtask

  function automatic cyc_t mk(input bit en, input bit we, input int a,
                              input int unsigned wd, input bit dn, input int t);
    cyc_t c;
    c.en = en; c.we = we; c.addr = 16'(a); c.wd = wd; c.dn = dn; c.tag = 4'(t);
    return c;
  endfunction

  // Builds the expected per-cycle schedule and updates ref_mem behaviourally
  task automatic build_expect();
    int unsigned rounds, nodes, batch, nb, ib, vb;
    exp_q.delete();
    for (int h = 0; h < 7; h++) exp_q.push_back(mk(1, 0, h, 0, 0, 1));
    exp_q.push_back(mk(0, 0, 0, 0, 0, 1));
    rounds = ref_mem[0]; nodes = ref_mem[1]; batch = ref_mem[2];
    nb = ref_mem[4]; ib = ref_mem[5]; vb = ref_mem[6];
    if (rounds == 0 || batch == 0) begin
      exp_q.push_back(mk(0, 0, 0, 0, 1, 7));
      return;
    end
    for (int unsigned r = 0; r < rounds; r++) begin
      for (int unsigned w = 0; w < batch; w++) begin
        int unsigned ia, va, na, idx, v, nv;
        longint unsigned cand;
        ia = (ib + w) & 16'hFFFF;
        va = (vb + w) & 16'hFFFF;
        idx = ref_mem[ia & 255];
        v = ref_mem[va & 255];
        na = (nb + idx) & 16'hFFFF;
        nv = ref_hash(v ^ ref_mem[na & 255]);
        cand = 2 * longint'(idx) + ((nv % 2 == 0) ? 1 : 2);
        if (cand >= longint'(nodes)) cand = 0;
        exp_q.push_back(mk(1, 0, ia, 0, 0, 2));
        exp_q.push_back(mk(1, 0, va, 0, 0, 2));
        exp_q.push_back(mk(1, 0, na, 0, 0, 2));
        exp_q.push_back(mk(1, 1, va, nv, 0, 3));
        exp_q.push_back(mk(1, 1, ia, 32'(cand), 0, 4));
        ref_mem[va & 255] = nv;
        ref_mem[ia & 255] = 32'(cand);
      end
    end
    exp_q.push_back(mk(0, 0, 0, 0, 1, 8));
  endtask

  task automatic cmp_cycle(input cyc_t e);
    bit bad;
    checks++;
    bad = (mem_en !== e.en) || (done !== e.dn);
    if (e.en && (mem_we !== e.we || mem_addr !== e.addr)) bad = 1;
    if (e.en && e.we && mem_wdata !== e.wd) bad = 1;
    if (bad) begin
      failures++;
      $display("FAIL %s: got en=%0b we=%0b addr=%0h wd=%0h done=%0b exp en=%0b we=%0b addr=%0h wd=%0h done=%0b",
               tag_name(e.tag), mem_en, mem_we, mem_addr, mem_wdata, done,
               e.en, e.we, e.addr, e.wd, e.dn);
    end
  endtask

  // Runs a job; poke_at >= 0 pulses start at that schedule position (R9)
  task automatic run_job(input int poke_at, input bit poke_done);
    int n;
    build_expect();
    n = exp_q.size();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int k = 0; k < n; k++) begin
      cmp_cycle(exp_q[k]);
      start = (k == poke_at) || (poke_done && k == n - 1);
      @(negedge clk);
      start = 1'b0;
    end
    for (int k = 0; k < 4; k++) begin  // R9, R10: quiet after done
      cmp_cycle(mk(0, 0, 0, 0, 0, 0));
      @(negedge clk);
    end
    begin : mem_cmp  // R6: final memory image
      int bad = 0;
      for (int a = 0; a < 256; a++) if (tb_mem[a] !== ref_mem[a]) bad++;
      checks++;
      if (bad != 0) begin
        failures++;
        $display("FAIL R6: memory words differing got=%0d exp=0", bad);
      end
    end
  endtask

  task automatic setup(input int unsigned rounds, nodes, batch, height, nb, ib, vb,
                       input int unsigned idx0, step);
    for (int a = 0; a < 256; a++) put(a, 0);
    put(0, rounds); put(1, nodes); put(2, batch); put(3, height);
    put(4, nb); put(5, ib); put(6, vb);
    for (int n = 0; n < 40; n++) begin
      seed = seed * 1103515245 + 12345;
      if (nb + n < 256) put(nb + n, seed >> 2);
    end
    for (int w = 0; w < 8; w++) begin
      seed = seed * 1103515245 + 12345;
      if (vb + w < 256) put(vb + w, seed >> 2);
      if (ib + w < 256 && nodes != 0) put(ib + w, (idx0 + w * step) % nodes);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish got=hung exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;  // R10 reset state
    if (done !== 1'b0 || mem_en !== 1'b0) begin
      failures++;
      $display("FAIL R10: reset got done=%0b en=%0b exp 0 0", done, mem_en);
    end
    rst_n = 1'b1;
    @(negedge clk);

    setup(3, 7, 4, 2, 10, 20, 30, 0, 2);       // R3 R4 R5: wraps in round 3
    run_job(-1, 0);
    setup(5, 15, 3, 3, 40, 60, 70, 0, 7);      // R6, R9 start mid-run and at done
    run_job(12, 1);
    setup(0, 7, 4, 2, 10, 20, 30, 1, 1);       // R7 zero rounds
    run_job(-1, 0);
    setup(2, 7, 0, 2, 10, 20, 30, 1, 1);       // R7 zero batch
    run_job(-1, 0);
    setup(1, 32'hFFFF_FFFF, 1, 31, 100, 120, 130, 0, 0);  // R5 33-bit candidate
    put(120, 32'h8000_0000);
    run_job(-1, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule